// File: doc/BRIEF.md
# DC-Only Residual Reconstruction Unit

This unit rebuilds a square block of 8-bit luma pixels in the special case where the DC term is the only non-zero residual coefficient. It is given the quantized DC coefficient, a scale factor, a weight factor, a left-shift count (the quantizer parameter divided by six) and a block-size select. From these it derives one signed residual. It adds that residual to every predicted pixel of the block and clamps each sum to 0..255.

A block begins with a start handshake that captures all scalar inputs. One setup cycle then turns them into the residual. After that, prediction rows enter one per beat on a valid/ready channel and leave in the same order, one reconstructed row per beat. The final row carries a last flag. In small-block mode an intra bypass takes a DC value that is already dequantized and skips the scaling arithmetic. No new block is taken until the current block's last row has been delivered.

Top module: `dcrecon_top`

## Requirements
- R1: Normal dequantization. The low 16 bits of (scale × weight), read as a signed 16-bit value, are multiplied by the signed coefficient to give a 32-bit product. That product is shifted left by `qp_shift` with wrap-around in 32 bits. In small mode (`big_mode`=0) the result is then rounded right by 4: add 8, arithmetic shift right by 4.
- R2: In large mode (`big_mode`=1) the rounding right shift of R1 is by 6: add 32, shift right by 6.
- R3: The rounded value is saturated to the range -32768..32767. The residual is (DC + 32) arithmetically shifted right by 6, so it always lies in -512..512.
- R4: In small mode, when `start_idx` equals 1, `alt_dc` is used as the DC directly and coefficient, scale, weight and shift are ignored.
- R5: In large mode, `start_idx` and `alt_dc` have no effect on the output.
- R6: Each output pixel equals the prediction pixel plus the residual, clamped to 0..255.
- R7: A small block has 4 rows of 4 pixels and a large block has 8 rows of 8 pixels. Rows leave in arrival order, and `recon_last` is high on the final row only. The unit returns to idle on the cycle after the last row is handed over.
- R8: After reset, `start_ready`=1 and `recon_valid`=0. `start_ready` is high only while idle, so no block is accepted while another is in flight. A held output row (valid high, ready low) keeps its data and last flag unchanged.
- R9: Pixel lane i occupies bits [8i+7:8i] of the row buses. In small mode lanes 4..7 of `pred_row` are ignored and driven as zero on `recon_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Block parameters offered |
| start_ready | output | 1 | Unit idle and able to take a block |
| big_mode | input | 1 | 1 = 8x8 block, 0 = 4x4 block |
| coef | input | 16 | Signed quantized DC coefficient |
| scale | input | 16 | Unsigned inverse scale factor |
| weight | input | 16 | Unsigned weighting factor |
| qp_shift | input | 4 | Left-shift count (QP/6) |
| start_idx | input | 4 | Start index; 1 selects intra bypass in small mode |
| alt_dc | input | 16 | Signed pre-dequantized DC for the bypass |
| pred_valid | input | 1 | Prediction row offered |
| pred_ready | output | 1 | Prediction row accepted this cycle |
| pred_row | input | 64 | Eight 8-bit prediction pixels |
| recon_valid | output | 1 | Reconstructed row available |
| recon_ready | input | 1 | Downstream accepts the row |
| recon_row | output | 64 | Eight 8-bit reconstructed pixels |
| recon_last | output | 1 | Final row of the block |

## Verification
The bench goes after the arithmetic edges. One case drives a large coefficient with a large shift so the rounded value saturates. A design without saturation would wrap to a negative residual and darken the block instead of saturating it. Another case uses scale and weight whose product overflows 16 bits, so keeping the full product gives the wrong DC. Other cases use negative DC values and residuals that push pixels below 0 or above 255, and a wrong floor or clamp shows up as pixels off by one or wrapped. The bypass is tried with a garbage coefficient, and the large mode is tried with a start index of 1, so that selecting the wrong DC source changes pixel values. Random backpressure on both row channels tests row order, the last flag and the hold of a stalled row.

// File: rtl/dcrecon_pkg.sv
package dcrecon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } dcr_state_e;

  localparam int SMALL_DIM = 4;
  localparam int BIG_DIM   = 8;
endpackage

// File: rtl/dcrecon_dequant.sv
module dcrecon_dequant #(
  parameter int COEF_W = 16,
  parameter int QP_W   = 4,
  parameter int IDX_W  = 4,
  localparam int RES_W = COEF_W - 5
) (
  input  logic                     big_mode,
  input  logic signed [COEF_W-1:0] coef,
  input  logic        [COEF_W-1:0] scale,
  input  logic        [COEF_W-1:0] weight,
  input  logic        [QP_W-1:0]   qp_shift,
  input  logic        [IDX_W-1:0]  start_idx,
  input  logic signed [COEF_W-1:0] alt_dc,
  output logic signed [RES_W-1:0]  resid
);
  localparam int PROD_W = 2 * COEF_W;
  localparam logic signed [PROD_W:0] SAT_HI = $signed((PROD_W+1)'(2**(COEF_W-1) - 1));
  localparam logic signed [PROD_W:0] SAT_LO = ~SAT_HI;

  logic        [PROD_W-1:0] sw_prod;
  logic signed [COEF_W-1:0] sw_low;
  logic signed [PROD_W-1:0] raw_prod;
  logic signed [PROD_W-1:0] shl_prod;
  logic signed [PROD_W:0]   rnd_sum;
  logic signed [PROD_W:0]   rnd_q;
  logic signed [COEF_W-1:0] dc_sat;
  logic signed [COEF_W-1:0] dc_sel;
  logic signed [COEF_W:0]   dc_bias;
  logic signed [COEF_W:0]   dc_shift;
  logic                     use_alt;

  // scale x weight, only the low half is kept
  always_comb begin
    sw_prod = PROD_W'(scale) * PROD_W'(weight);
    sw_low  = $signed(sw_prod[COEF_W-1:0]);
  end

  // signed product, then left shift wrapping in PROD_W bits
  always_comb begin
    raw_prod = $signed({{COEF_W{sw_low[COEF_W-1]}}, sw_low}) *
               $signed({{COEF_W{coef[COEF_W-1]}}, coef});
    shl_prod = raw_prod <<< qp_shift;
  end

  // rounding right shift; distance picked by block size
  always_comb begin
    if (big_mode) begin
      rnd_sum = {shl_prod[PROD_W-1], shl_prod} + $signed((PROD_W+1)'(32));
      rnd_q   = rnd_sum >>> 6;
    end else begin
      rnd_sum = {shl_prod[PROD_W-1], shl_prod} + $signed((PROD_W+1)'(8));
      rnd_q   = rnd_sum >>> 4;
    end
  end

  // saturation to signed COEF_W
  always_comb begin
    if (rnd_q > SAT_HI) begin
      dc_sat = SAT_HI[COEF_W-1:0];
    end else if (rnd_q < SAT_LO) begin
      dc_sat = SAT_LO[COEF_W-1:0];
    end else begin
      dc_sat = rnd_q[COEF_W-1:0];
    end
  end

  // bypass select and final rounding to the residual
  always_comb begin
    use_alt  = !big_mode && (start_idx == IDX_W'(1));
    dc_sel   = use_alt ? alt_dc : dc_sat;
    dc_bias  = {dc_sel[COEF_W-1], dc_sel} + $signed((COEF_W+1)'(32));
    dc_shift = dc_bias >>> 6;
    resid    = dc_shift[RES_W-1:0];
  end
endmodule

// File: rtl/dcrecon_row_add.sv
module dcrecon_row_add #(
  parameter int LANES       = 8,
  parameter int SMALL_LANES = 4,
  parameter int PIX_W       = 8,
  parameter int RES_W       = 11
) (
  input  logic                     big_mode,
  input  logic [LANES*PIX_W-1:0]   pred_row,
  input  logic signed [RES_W-1:0]  resid,
  output logic [LANES*PIX_W-1:0]   recon_row
);
  localparam int SUM_W = RES_W + 1;
  localparam logic signed [SUM_W-1:0] PIX_MAX = $signed(SUM_W'(2**PIX_W - 1));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [SUM_W-1:0] sum;
    logic        [PIX_W-1:0] clip;
    logic                    lane_on;

    always_comb begin
      lane_on = big_mode || (g < SMALL_LANES);
      sum     = $signed({{(SUM_W-PIX_W){1'b0}}, pred_row[g*PIX_W +: PIX_W]}) +
                $signed({resid[RES_W-1], resid});
      if (sum < 0) begin
        clip = '0;
      end else if (sum > PIX_MAX) begin
        clip = '1;
      end else begin
        clip = sum[PIX_W-1:0];
      end
      recon_row[g*PIX_W +: PIX_W] = lane_on ? clip : '0;
    end
  end
endmodule

// File: rtl/dcrecon_ctrl.sv
module dcrecon_ctrl
  import dcrecon_pkg::*;
#(
  parameter int MAX_ROWS = 8,
  localparam int ROW_CW  = $clog2(MAX_ROWS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_valid,
  input  logic big_mode_q,
  input  logic pred_valid,
  input  logic recon_ready,
  output logic start_ready,
  output logic cfg_load,
  output logic resid_load,
  output logic pred_ready,
  output logic out_load,
  output logic recon_valid,
  output logic recon_last
);
  dcr_state_e        state_q, state_d;
  logic [ROW_CW-1:0] in_cnt_q, in_cnt_d;
  logic [ROW_CW-1:0] rows;
  logic              valid_q, valid_d;
  logic              last_q, last_d;
  logic              out_free;
  logic              blk_done;

  always_comb begin
    rows        = big_mode_q ? ROW_CW'(BIG_DIM) : ROW_CW'(SMALL_DIM);
    start_ready = (state_q == ST_IDLE);
    cfg_load    = start_ready && start_valid;
    resid_load  = (state_q == ST_SETUP);
    out_free    = !valid_q || recon_ready;
    pred_ready  = (state_q == ST_RUN) && (in_cnt_q != rows) && out_free;
    out_load    = pred_ready && pred_valid;
    blk_done    = valid_q && recon_ready && last_q;
  end

  always_comb begin
    state_d  = state_q;
    in_cnt_d = in_cnt_q;
    valid_d  = valid_q;
    last_d   = last_q;
    unique case (state_q)
      ST_IDLE:  if (cfg_load) begin
                  state_d  = ST_SETUP;
                  in_cnt_d = '0;
                end
      ST_SETUP: state_d = ST_RUN;
      ST_RUN:   if (blk_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (out_load) begin
      in_cnt_d = in_cnt_q + ROW_CW'(1);
      valid_d  = 1'b1;
      last_d   = (in_cnt_q == rows - ROW_CW'(1));
    end else if (recon_ready) begin
      valid_d  = 1'b0;
      last_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      in_cnt_q <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      in_cnt_q <= in_cnt_d;
      valid_q  <= valid_d;
      last_q   <= last_d;
    end
  end

  assign recon_valid = valid_q;
  assign recon_last  = last_q;

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_valid && !recon_ready) |=> (recon_valid && $stable(recon_last)));

  a_r8_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    recon_valid |-> !start_ready);

  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_valid && recon_ready && recon_last) |=> start_ready);

  a_r7_last_after_all_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_valid && recon_last) |-> (in_cnt_q == rows));
endmodule

// File: rtl/dcrecon_top.sv
module dcrecon_top
  import dcrecon_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int QP_W   = 4,
  parameter int IDX_W  = 4,
  parameter int PIX_W  = 8,
  localparam int LANES = BIG_DIM,
  localparam int ROW_W = LANES * PIX_W,
  localparam int RES_W = COEF_W - 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              big_mode,
  input  logic [COEF_W-1:0] coef,
  input  logic [COEF_W-1:0] scale,
  input  logic [COEF_W-1:0] weight,
  input  logic [QP_W-1:0]   qp_shift,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [COEF_W-1:0] alt_dc,
  input  logic              pred_valid,
  output logic              pred_ready,
  input  logic [ROW_W-1:0]  pred_row,
  output logic              recon_valid,
  input  logic              recon_ready,
  output logic [ROW_W-1:0]  recon_row,
  output logic              recon_last
);
  localparam logic signed [RES_W-1:0] RES_MAG = RES_W'(2**(COEF_W-7));

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic cfg_load, resid_load, out_load;

  // captured block parameters
  logic              mode_q;
  logic [COEF_W-1:0] coef_q, scale_q, weight_q, alt_q;
  logic [QP_W-1:0]   qp_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      mode_q   <= 1'b0;
      coef_q   <= '0;
      scale_q  <= '0;
      weight_q <= '0;
      alt_q    <= '0;
      qp_q     <= '0;
      idx_q    <= '0;
    end else if (cfg_load) begin
      mode_q   <= big_mode;
      coef_q   <= coef;
      scale_q  <= scale;
      weight_q <= weight;
      alt_q    <= alt_dc;
      qp_q     <= qp_shift;
      idx_q    <= start_idx;
    end
  end

  logic signed [RES_W-1:0] resid_d, resid_q;

  dcrecon_dequant #(
    .COEF_W(COEF_W), .QP_W(QP_W), .IDX_W(IDX_W)
  ) u_dequant (
    .big_mode (mode_q),
    .coef     ($signed(coef_q)),
    .scale    (scale_q),
    .weight   (weight_q),
    .qp_shift (qp_q),
    .start_idx(idx_q),
    .alt_dc   ($signed(alt_q)),
    .resid    (resid_d)
  );

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      resid_q <= '0;
    end else if (resid_load) begin
      resid_q <= resid_d;
    end
  end

  logic [ROW_W-1:0] sum_row, out_q;

  dcrecon_row_add #(
    .LANES(LANES), .SMALL_LANES(SMALL_DIM), .PIX_W(PIX_W), .RES_W(RES_W)
  ) u_row_add (
    .big_mode (mode_q),
    .pred_row (pred_row),
    .resid    (resid_q),
    .recon_row(sum_row)
  );

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      out_q <= '0;
    end else if (out_load) begin
      out_q <= sum_row;
    end
  end

  dcrecon_ctrl #(.MAX_ROWS(BIG_DIM)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .start_valid(start_valid),
    .big_mode_q (mode_q),
    .pred_valid (pred_valid),
    .recon_ready(recon_ready),
    .start_ready(start_ready),
    .cfg_load   (cfg_load),
    .resid_load (resid_load),
    .pred_ready (pred_ready),
    .out_load   (out_load),
    .recon_valid(recon_valid),
    .recon_last (recon_last)
  );

  assign recon_row = out_q;

  a_r3_resid_range: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (resid_q >= -RES_MAG) && (resid_q <= RES_MAG));

  a_r8_row_held: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (recon_valid && !recon_ready) |=> $stable(recon_row));

  a_r9_small_upper_zero: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (recon_valid && !mode_q) |-> (recon_row[ROW_W-1:ROW_W/2] == '0));
endmodule

// File: tb/sim_dcrecon_top.sv
`timescale 1ns/1ps
module sim_dcrecon_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_valid, start_ready, big_mode;
  logic [15:0] coef, scale, weight, alt_dc;
  logic [3:0]  qp_shift, start_idx;
  logic        pred_valid, pred_ready, recon_valid, recon_ready, recon_last;
  logic [63:0] pred_row, recon_row;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [63:0] pmem [8];

  always #2 clk = ~clk;

  dcrecon_top u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .big_mode(big_mode), .coef(coef), .scale(scale), .weight(weight),
    .qp_shift(qp_shift), .start_idx(start_idx), .alt_dc(alt_dc),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_row(pred_row),
    .recon_valid(recon_valid), .recon_ready(recon_ready), .recon_row(recon_row),
    .recon_last(recon_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_resid(input bit m8, input logic [15:0] c, input logic [15:0] s,
                                   input logic [15:0] w, input logic [3:0] q,
                                   input logic [3:0] idx, input logic [15:0] alt);
    int dc;
    if (!m8 && idx == 4'd1) begin
      dc = int'($signed(alt));
    end else begin
      int unsigned sw;
      int lo, p, sh;
      longint r;
      sw = (int'(s) * int'(w)) & 32'hFFFF;
      lo = (sw >= 32768) ? int'(sw) - 65536 : int'(sw);
      p  = lo * int'($signed(c));
      p  = p << q;
      sh = m8 ? 6 : 4;
      r  = (longint'(p) + (longint'(1) << (sh - 1))) >>> sh;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      dc = int'(r);
    end
    return (dc + 32) >>> 6;
  endfunction

  function automatic logic [63:0] ref_row(input bit m8, input int res, input logic [63:0] p);
    logic [63:0] o = '0;
    for (int i = 0; i < (m8 ? 8 : 4); i++) begin
      int v = int'(p[i*8 +: 8]) + res;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      o[i*8 +: 8] = v[7:0];
    end
    return o;
  endfunction

  task automatic run_block(input bit m8, input logic [15:0] c, input logic [15:0] s,
                           input logic [15:0] w, input logic [3:0] q,
                           input logic [3:0] idx, input logic [15:0] alt, input int pmode);
    int rows = m8 ? 8 : 4;
    int res = ref_resid(m8, c, s, w, q, idx, alt);
    bit acc;
    for (int k = 0; k < 8; k++) begin
      case (pmode)
        1: pmem[k] = '0;
        2: pmem[k] = '1;
        default: pmem[k] = {$urandom, $urandom};
      endcase
    end
    @(negedge clk);
    start_valid = 1'b1; big_mode = m8; coef = c; scale = s; weight = w;
    qp_shift = q; start_idx = idx; alt_dc = alt;
    forever begin
      #1 acc = start_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    start_valid = 1'b0;
    coef = 16'($urandom); scale = 16'($urandom); weight = 16'($urandom);
    qp_shift = 4'($urandom); start_idx = 4'($urandom); alt_dc = 16'($urandom);
    big_mode = ~m8;
    #1 chk(start_ready == 1'b0, "R8 start_ready low while busy", 64'(start_ready), 64'd0);
    fork
      begin : drv
        for (int k = 0; k < rows; k++) begin
          bit f;
          @(negedge clk);
          if ($urandom_range(0, 3) == 0) begin
            pred_valid = 1'b0;
            pred_row = {$urandom, $urandom};
            @(negedge clk);
          end
          pred_valid = 1'b1;
          pred_row = pmem[k];
          forever begin
            #1 f = pred_ready;
            @(posedge clk);
            if (f) break;
            @(negedge clk);
          end
        end
        @(negedge clk);
        pred_valid = 1'b0;
      end
      begin : mon
        int k = 0;
        while (k < rows) begin
          @(negedge clk);
          recon_ready = ($urandom_range(0, 3) != 0);
          #1;
          if (recon_valid && recon_ready) begin
            logic [63:0] e = ref_row(m8, res, pmem[k]);
            chk(recon_row == e, m8 ? "R2 R6 R9 row data (8x8)" : "R1 R6 R9 row data (4x4)",
                recon_row, e);
            chk(recon_last == (k == rows - 1), "R7 last flag position",
                64'(recon_last), 64'(k == rows - 1));
            k++;
          end
        end
        @(negedge clk);
        recon_ready = 1'b0;
        #1 chk(start_ready == 1'b1, "R7 idle after last row", 64'(start_ready), 64'd1);
      end
    join
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start_valid = 1'b0; big_mode = 1'b0; coef = '0; scale = '0;
    weight = '0; qp_shift = '0; start_idx = '0; alt_dc = '0;
    pred_valid = 1'b0; pred_row = '0; recon_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(start_ready == 1'b1, "R8 reset start_ready", 64'(start_ready), 64'd1);
    chk(recon_valid == 1'b0, "R8 reset recon_valid", 64'(recon_valid), 64'd0);

    // R1 plain small block
    run_block(1'b0, 16'd5, 16'd16, 16'd16, 4'd0, 4'd0, 16'd0, 0);
    // R1 scale*weight overflowing 16 bits
    run_block(1'b0, 16'd3, 16'd300, 16'd300, 4'd1, 4'd0, 16'd0, 0);
    // R3 positive saturation -> all 255 (R6)
    run_block(1'b0, 16'h7FFF, 16'd255, 16'd255, 4'd8, 4'd0, 16'd0, 0);
    // R3 negative saturation -> all 0 (R6)
    run_block(1'b0, 16'h8000, 16'd255, 16'd255, 4'd8, 4'd0, 16'd0, 2);
    // R4 intra bypass, negative DC with floor rounding
    run_block(1'b0, 16'h7FFF, 16'hFFFF, 16'hFFFF, 4'd8, 4'd1, -16'sd640, 0);
    // R4 bypass extremes
    run_block(1'b0, 16'd0, 16'd0, 16'd0, 4'd0, 4'd1, 16'h7FFF, 1);
    run_block(1'b0, 16'd0, 16'd0, 16'd0, 4'd0, 4'd1, 16'h8000, 2);
    // R2 large block, rounding by 6
    run_block(1'b1, 16'd40, 16'd16, 16'd16, 4'd2, 4'd0, 16'd0, 0);
    // R5 large block ignores start_idx=1 and alt_dc
    run_block(1'b1, 16'd7, 16'd20, 16'd16, 4'd0, 4'd1, 16'h7FFF, 0);
    run_block(1'b1, -16'sd9, 16'd25, 16'd16, 4'd3, 4'd1, 16'h8000, 0);

    for (int n = 0; n < 40; n++) begin
      run_block(1'($urandom), 16'($urandom_range(0, 2000)) - 16'd1000,
                16'($urandom_range(0, 40)), 16'($urandom_range(0, 40)),
                4'($urandom_range(0, 8)), 4'($urandom_range(0, 2)),
                16'($urandom_range(0, 20000)) - 16'd10000, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule